// File: doc/BRIEF.md
# Word-Parallel Link CRC Generator

This block computes a 32-bit cyclic redundancy check over a stream of 32-bit words, absorbing one complete word into its register on every clock for which the enable is high. Each update XORs the incoming word into the running value and then passes the result through a fixed XOR network. That network is equivalent to thirty-two single-bit shifts of a linear feedback register built on the generator polynomial 0x04C11DB7, with bit 31 taken as the most significant bit. The register starts from a non-zero link seed instead of all ones.

A link layer feeds the payload words, then the received CRC word, with the enable high. It then reads the error flag on the next enabled cycle. A small two-state controller records whether any word has been absorbed since the last reset. The error flag is only valid once a word has been absorbed. At that point it compares the register with a fixed residue.

Top module: `crc_link_gen`

## Requirements
- R1: A synchronous reset (srst_i high at a rising edge) loads crc_o with the seed 0x52325032 and puts the controller in state ST_SEED (no word absorbed). The transition taken is RESET->ST_SEED.
- R2: While en_i is low and srst_i is low, crc_o keeps its value across clock edges.
- R3: While en_i is high and srst_i is low, each rising edge loads crc_o with M(crc_o XOR word_i). M applies 32 times the step "shift left one bit and, if the bit shifted out (bit 31) was 1, XOR with 0x04C11DB7".
- R4: In the network M, new bit 31 is the XOR of combined bits 31, 30, 29, 28, 27, 25, 24, 23, 15, 11, 9, 8 and 5. New bit 0 is the XOR of combined bits 31, 30, 29, 28, 26, 25, 24, 16, 12, 10, 9, 6 and 0. Here "combined" means crc_o XOR word_i.
- R5: The first enabled edge after reset moves the controller from ST_SEED to ST_RUN (transition SEED->RUN). It stays in ST_RUN until the next reset.
- R6: err_o is high exactly when en_i is high, the controller is in ST_RUN, and crc_o differs from the residue 0xC704DD7B. Otherwise it is low. In particular it is low in ST_SEED and whenever en_i is low.
- R7: srst_i has priority over en_i. A reset with the enable high still loads the seed and returns the controller to ST_SEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| srst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Clock enable; absorbs word_i at the edge when high |
| word_i | input | 32 | Data word to fold into the CRC |
| crc_o | output | 32 | Current CRC register value |
| err_o | output | 1 | Residue mismatch flag (see R6) |

## Verification
Pseudo-random words (index*0x31415979+1) exercise every column of the XOR network densely. Comparing each step against a software shift model exposes any wrong matrix row. Counting words (0, 1, 2, ...) have sparse, low-bit patterns that separate errors in the low rows and in the XOR-before-matrix ordering. A crafted final word, derived by running the shift model backwards from the residue, lands the register exactly on 0xC704DD7B. This shows that the error flag falls on a match and rises on a mismatch. Runs with the enable held low, and a reset asserted together with the enable, separate the hold behaviour and the reset priority from normal advance.

// File: rtl/crc_link_pkg.sv
package crc_link_pkg;

    localparam int CRC_W = 32;

    typedef logic [CRC_W-1:0] crc_word_t;

    typedef enum logic [0:0] {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } crc_state_e;

    // One word step of an MSB-first shift register: CRC_W single-bit shifts.
    function automatic crc_word_t crc_shift_word(input crc_word_t val, input crc_word_t poly);
        crc_word_t c;
        c = val;
        for (int k = 0; k < CRC_W; k++) begin
            if (c[CRC_W-1]) c = (c << 1) ^ poly;
            else            c = c << 1;
        end
        return c;
    endfunction

    // Mask of combined-word bits that feed output bit 'row' of the network.
    function automatic crc_word_t crc_row_mask(input int row, input crc_word_t poly);
        crc_word_t m;
        crc_word_t col;
        m = '0;
        for (int j = 0; j < CRC_W; j++) begin
            col = crc_shift_word(crc_word_t'(1) << j, poly);
            m[j] = col[row];
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_link_matrix.sv
module crc_link_matrix
    import crc_link_pkg::*;
#(
    parameter crc_word_t POLY = 32'h04C1_1DB7
) (
    input  crc_word_t comb_i,
    output crc_word_t next_o
);

    for (genvar i = 0; i < CRC_W; i++) begin : g_row
        localparam crc_word_t ROW_MASK = crc_row_mask(i, POLY);
        assign next_o[i] = ^(comb_i & ROW_MASK);
    end

endmodule

// File: rtl/crc_link_ctrl.sv
module crc_link_ctrl
    import crc_link_pkg::*;
(
    input  logic clk_i,
    input  logic srst_i,
    input  logic en_i,
    output logic load_seed_o,
    output logic advance_o,
    output logic absorbed_o
);

    crc_state_e state_q;
    crc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED: if (en_i) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_SEED;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (srst_i) state_q <= ST_SEED;
        else        state_q <= state_d;
    end

    always_comb begin
        load_seed_o = srst_i;
        advance_o   = !srst_i && en_i;
        absorbed_o  = 1'b0;
        unique case (state_q)
            ST_SEED: absorbed_o = 1'b0;
            ST_RUN:  absorbed_o = 1'b1;
            default: absorbed_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/crc_link_gen.sv
module crc_link_gen
    import crc_link_pkg::*;
#(
    parameter logic [31:0] POLY    = 32'h04C1_1DB7,
    parameter logic [31:0] SEED    = 32'h5232_5032,
    parameter logic [31:0] RESIDUE = 32'hC704_DD7B
) (
    input  logic        clk_i,
    input  logic        srst_i,
    input  logic        en_i,
    input  logic [31:0] word_i,
    output logic [31:0] crc_o,
    output logic        err_o
);

    crc_word_t crc_q;
    crc_word_t comb_w;
    crc_word_t next_w;
    logic      load_seed_w;
    logic      advance_w;
    logic      absorbed_w;

    crc_link_ctrl u_ctrl (
        .clk_i      (clk_i),
        .srst_i     (srst_i),
        .en_i       (en_i),
        .load_seed_o(load_seed_w),
        .advance_o  (advance_w),
        .absorbed_o (absorbed_w)
    );

    assign comb_w = crc_q ^ word_i;

    crc_link_matrix #(.POLY(POLY)) u_matrix (
        .comb_i(comb_w),
        .next_o(next_w)
    );

    always_ff @(posedge clk_i) begin
        if (load_seed_w)    crc_q <= SEED;
        else if (advance_w) crc_q <= next_w;
    end

    assign crc_o = crc_q;
    assign err_o = en_i && absorbed_w && (crc_q != RESIDUE);

endmodule

// File: rtl/crc_link_gen_chk.sv
module crc_link_gen_chk
    import crc_link_pkg::*;
#(
    parameter logic [31:0] POLY    = 32'h04C1_1DB7,
    parameter logic [31:0] SEED    = 32'h5232_5032,
    parameter logic [31:0] RESIDUE = 32'hC704_DD7B
) (
    input logic        clk_i,
    input logic        srst_i,
    input logic        en_i,
    input logic [31:0] word_i,
    input logic [31:0] crc_o,
    input logic        err_o
);

    // R1: the cycle after reset is released, the seed is present and err_o is low
    assert_seed_after_reset_R1: assert property (@(posedge clk_i) disable iff (srst_i)
        $fell(srst_i) |-> (crc_o == SEED) && !err_o);

    // R2: disabled cycles leave the register untouched
    assert_hold_when_idle_R2: assert property (@(posedge clk_i) disable iff (srst_i)
        !en_i |=> $stable(crc_o));

    // R3: enabled cycles apply the word step of the shift model
    assert_word_step_R3: assert property (@(posedge clk_i) disable iff (srst_i)
        en_i |=> crc_o == crc_shift_word($past(crc_o) ^ $past(word_i), POLY));

    // R6: error never raised without enable or on a matching residue
    assert_err_needs_en_R6: assert property (@(posedge clk_i) disable iff (srst_i)
        err_o |-> en_i && (crc_o != RESIDUE));

    // R5: after one enabled edge a mismatch with the enable high is flagged
    assert_err_after_absorb_R5: assert property (@(posedge clk_i) disable iff (srst_i)
        en_i |=> (en_i && crc_o != RESIDUE) |-> err_o);

endmodule

bind crc_link_gen crc_link_gen_chk #(
    .POLY(POLY), .SEED(SEED), .RESIDUE(RESIDUE)
) u_chk (
    .clk_i(clk_i), .srst_i(srst_i), .en_i(en_i),
    .word_i(word_i), .crc_o(crc_o), .err_o(err_o)
);

// File: tb/crc_link_gen_tb_top.sv
`timescale 1ns/1ps
module crc_link_gen_tb_top;

    localparam logic [31:0] P_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] P_SEED    = 32'h5232_5032;
    localparam logic [31:0] P_RESIDUE = 32'hC704_DD7B;

    logic        clk = 1'b0;
    logic        srst_i = 1'b1;
    logic        en_i = 1'b0;
    logic [31:0] word_i = '0;
    logic [31:0] crc_o;
    logic        err_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] model = P_SEED;
    bit model_run = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crc_link_gen dut_i (
        .clk_i(clk), .srst_i(srst_i), .en_i(en_i),
        .word_i(word_i), .crc_o(crc_o), .err_o(err_o)
    );

    function automatic logic [31:0] sw_step(input logic [31:0] c0, input logic [31:0] d);
        logic [31:0] c;
        c = c0 ^ d;
        for (int k = 0; k < 32; k++) c = c[31] ? ((c << 1) ^ P_POLY) : (c << 1);
        return c;
    endfunction

    function automatic logic [31:0] sw_unstep(input logic [31:0] t);
        logic [31:0] c;
        c = t;
        for (int k = 0; k < 32; k++) c = c[0] ? (((c ^ P_POLY) >> 1) | 32'h8000_0000) : (c >> 1);
        return c;
    endfunction

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive away from the edge, clock once, settle.
    task automatic step(input logic rst, input logic en, input logic [31:0] d);
        srst_i = rst; en_i = en; word_i = d;
        @(posedge clk); #1;
        if (rst) begin model = P_SEED; model_run = 1'b0; end
        else if (en) begin model = sw_step(model, d); model_run = 1'b1; end
    endtask

    task automatic t_reset();
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b0, '0);
        srst_i = 1'b0;
        #0.5;
        chk32("R1 seed", crc_o, P_SEED);
        chk32("R1 err low", {31'd0, err_o}, 32'd0);
        en_i = 1'b1; #0.5;
        chk32("R6 err low in ST_SEED", {31'd0, err_o}, 32'd0);
        en_i = 1'b0;
    endtask

    task automatic t_stream(input bit rnd, input int len, input string req);
        logic [31:0] d;
        logic [31:0] prev;
        logic [31:0] comb;
        for (int i = 0; i < len; i++) begin
            d = rnd ? (i * 32'h3141_5979 + 32'd1) : i;
            prev = model;
            comb = prev ^ d;
            step(1'b0, 1'b1, d);
            chk32(req, crc_o, model);
            if (i == 3) begin
                chk32("R4 bit31", {31'd0, crc_o[31]}, {31'd0, comb[31]^comb[30]^comb[29]^comb[28]^comb[27]^
                      comb[25]^comb[24]^comb[23]^comb[15]^comb[11]^comb[9]^comb[8]^comb[5]});
                chk32("R4 bit0", {31'd0, crc_o[0]}, {31'd0, comb[31]^comb[30]^comb[29]^comb[28]^comb[26]^
                      comb[25]^comb[24]^comb[16]^comb[12]^comb[10]^comb[9]^comb[6]^comb[0]});
            end
            if (i == 0) chk32("R5 err after first word", {31'd0, err_o},
                              {31'd0, (model != P_RESIDUE)});
        end
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        keep = crc_o;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 32'hDEAD_0000 + i);
        chk32("R2 hold", crc_o, keep);
        chk32("R6 err low without enable", {31'd0, err_o}, 32'd0);
    endtask

    task automatic t_residue();
        logic [31:0] d;
        d = sw_unstep(P_RESIDUE) ^ model;
        step(1'b0, 1'b1, d);
        chk32("R3 lands on residue", crc_o, P_RESIDUE);
        chk32("R6 err low on match", {31'd0, err_o}, 32'd0);
        en_i = 1'b0; #0.5;
        chk32("R6 err low idle", {31'd0, err_o}, 32'd0);
        step(1'b0, 1'b1, 32'h0000_0001);
        chk32("R6 err high on mismatch", {31'd0, err_o}, {31'd0, (model != P_RESIDUE)});
    endtask

    task automatic t_reset_prio();
        step(1'b0, 1'b1, 32'h1234_5678);
        step(1'b1, 1'b1, 32'hFFFF_FFFF);
        chk32("R7 seed despite enable", crc_o, P_SEED);
        srst_i = 1'b0; #0.5;
        chk32("R7 back in ST_SEED", {31'd0, err_o}, 32'd0);
        step(1'b0, 1'b1, 32'hA5A5_A5A5);
        chk32("R3 after reset", crc_o, model);
    endtask

    initial begin
        t_reset();
        t_stream(1'b1, 64, "R3 random");
        t_hold();
        t_reset();
        t_stream(1'b0, 64, "R3 counting");
        t_residue();
        t_reset_prio();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule